// File: doc/BRIEF.md
# BT Request/Response Message Framer

This block sits between the host-facing register decode of a block-transfer style management interface and a command-processing backend. The host fills an inbound byte buffer and then raises a one-cycle request strobe. The framer checks the request's length byte and sets the controller-busy flag. It answers the interface-capabilities query on its own. Every other request goes out to the backend as a byte stream.

The outgoing stream carries the network function and command bytes and then the data bytes. The sequence byte is held back and kept locally. Each transfer is tagged with a rolling transaction ID. The backend returns a response under that same ID. The framer rebuilds the response in the outbound buffer, puts the saved sequence byte back into it, and replaces an oversized answer with a short error frame. It then clears controller-busy and emits a one-cycle completion event for the interrupt logic. The host drains the outbound buffer one byte at a time through a pop port.

The backend request stream uses a valid/ready handshake. The response stream has no ready signal: the framer takes a response byte whenever it is offered.

Top module: `bt_msg_framer`

## Requirements
- R1: After reset, busy, doneEvt and beValid are 0, outAvail is 0 and outByte reads 0xFF.
- R2: A request strobe with fewer than 4 inbound bytes sets busy and does nothing else. It produces no frame and no backend traffic, and it keeps the inbound bytes, so pushing more bytes completes the same request.
- R3: When byte 0 is not equal to (inbound length - 1), the request is dropped. Busy stays set, no frame is built, and the inbound length returns to 0, so the next pushed byte lands at index 0.
- R4: A request with byte 1 = 0x18 and byte 3 = 0x36 is answered locally with a 10-byte frame: 9, byte1|0x04, byte 2, byte 3, 0x00, 0x01, inbound capacity, outbound capacity, 0x0A, 0x00. Each capacity is capped at 255 (64 and 64 at the defaults).
- R5: Any other valid request is sent on the backend stream as byte 1, then bytes 3 to N-1, with beLast on the final byte and beId equal to the expected ID. beValid, beData, beLast and beId hold steady while beReady is low.
- R6: A response byte counts only when rspId equals the expected ID. A response under any other ID changes nothing. The expected ID starts at 0 and increments after each accepted response.
- R7: An accepted response of L bytes (netfn, cmd, data...) becomes the frame L+1, netfn, saved sequence, cmd, data..., with an outbound length of L+2.
- R8: A response longer than (outbound capacity - 2) becomes the 5-byte frame 4, netfn, saved sequence, cmd, 0xCA.
- R9: A local answer or the last byte of an accepted response clears busy and raises doneEvt for one cycle. doneEvt is never high while busy is high.
- R10: Request strobes are ignored while a forwarded request is outstanding (being sent or awaiting its response).
- R11: Each outPop returns the next frame byte in order. After the last byte, outAvail falls to 0 and outByte reads 0xFF.
- R12: A request that pushed more bytes than the inbound capacity is dropped in the same way as a length mismatch (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inPush | input | 1 | Append inByte to the inbound buffer |
| inByte | input | 8 | Inbound request byte |
| inClear | input | 1 | Empty the inbound buffer |
| reqGo | input | 1 | Request-ready strobe |
| busy | output | 1 | Controller-busy flag |
| doneEvt | output | 1 | One-cycle completion event |
| beValid | output | 1 | Backend request byte valid |
| beData | output | 8 | Backend request byte |
| beLast | output | 1 | Final byte of the backend request |
| beId | output | ID_W | Transaction ID of the backend request |
| beReady | input | 1 | Backend accepts the request byte |
| rspValid | input | 1 | Response byte valid |
| rspData | input | 8 | Response byte |
| rspLast | input | 1 | Final response byte |
| rspId | input | ID_W | Transaction ID of the response |
| outPop | input | 1 | Consume the current outbound byte |
| outByte | output | 8 | Current outbound byte, 0xFF when empty |
| outAvail | output | 1 | Outbound frame byte available |

## Verification
The hardest case to reach is the overrun drop. Its length byte equals the stored count minus one, so only the capacity check can reject it. The stimulus pushes one byte more than the inbound capacity, with byte 0 set to exactly that capacity. A second hard case is a response that arrives with a stale ID while a forward is outstanding. That needs a full forward handshake with a stalling backend first, then a wrong-ID response and an ignored strobe, before the matching response is finally checked.

// File: rtl/bt_framer_pkg.sv
package bt_framer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } frState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic dropReq;
    logic ansLocal;
    logic startFwd;
    logic sendByte;
    logic takeRsp;
    logic finRsp;
  } frCtl_t;

  // request observations from datapath to control
  typedef struct packed {
    logic shortReq;
    logic badLen;
    logic isCap;
    logic lastFwd;
  } frStat_t;

  localparam logic [7:0] NETFN_APP_REQ = 8'h18;
  localparam logic [7:0] CMD_CAP_QUERY = 8'h36;
  localparam logic [7:0] CC_TOO_LONG   = 8'hCA;

endpackage

// File: rtl/bt_framer_ctrl.sv
module bt_framer_ctrl
  import bt_framer_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqGo,
  input  frStat_t         stat,
  input  logic            beReady,
  input  logic            rspValid,
  input  logic            rspLast,
  input  logic [ID_W-1:0] rspId,
  output frCtl_t          ctl,
  output logic            busy,
  output logic            doneEvt,
  output logic            beValid,
  output logic            beLast,
  output logic [ID_W-1:0] beId
);

  frState_t        state;
  logic [ID_W-1:0] expId;
  logic            rspHit;

  always_comb begin
    ctl    = '0;
    rspHit = (state == ST_WAIT) && rspValid && (rspId == expId);
    if (state == ST_IDLE && reqGo && !stat.shortReq) begin
      if (stat.badLen)     ctl.dropReq  = 1'b1;
      else if (stat.isCap) ctl.ansLocal = 1'b1;
      else                 ctl.startFwd = 1'b1;
    end
    ctl.sendByte = (state == ST_SEND) && beReady;
    ctl.takeRsp  = rspHit;
    ctl.finRsp   = rspHit && rspLast;
  end

  assign beValid = (state == ST_SEND);
  assign beLast  = stat.lastFwd;
  assign beId    = expId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      doneEvt <= 1'b0;
      expId   <= '0;
    end else begin
      doneEvt <= ctl.ansLocal || ctl.finRsp;
      if (state == ST_IDLE && reqGo) busy <= !ctl.ansLocal;
      else if (ctl.finRsp)           busy <= 1'b0;
      if (ctl.finRsp) expId <= expId + 1'b1;
      unique case (state)
        ST_IDLE: if (ctl.startFwd) state <= ST_SEND;
        ST_SEND: if (ctl.sendByte && stat.lastFwd) state <= ST_WAIT;
        ST_WAIT: if (ctl.finRsp) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bt_framer_dp.sv
module bt_framer_dp
  import bt_framer_pkg::*;
#(
  parameter int IN_DEPTH  = 64,  // at least 4
  parameter int OUT_DEPTH = 64   // at least 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inPush,
  input  logic [7:0] inByte,
  input  logic       inClear,
  input  frCtl_t     ctl,
  output frStat_t    stat,
  output logic [7:0] fwdByte,
  input  logic [7:0] rspData,
  input  logic       outPop,
  output logic [7:0] outByte,
  output logic       outAvail
);

  localparam int IN_LW  = $clog2(IN_DEPTH) + 2;
  localparam int IN_IW  = $clog2(IN_DEPTH);
  localparam int OUT_LW = $clog2(OUT_DEPTH + 1);
  localparam int OUT_IW = $clog2(OUT_DEPTH);
  localparam int RC_W   = $clog2(OUT_DEPTH) + 3;
  localparam int CAP_LEN = 10;
  localparam logic [7:0] CAP_IN  = (IN_DEPTH  > 255) ? 8'd255 : 8'(IN_DEPTH);
  localparam logic [7:0] CAP_OUT = (OUT_DEPTH > 255) ? 8'd255 : 8'(OUT_DEPTH);

  logic [7:0]        inBuf [IN_DEPTH];
  logic [IN_LW-1:0]  inLen;
  logic [IN_IW-1:0]  fwdIdx;
  logic [7:0]        seqSaved;
  logic [7:0]        outBuf [OUT_DEPTH];
  logic [OUT_LW-1:0] outLen;
  logic [OUT_LW-1:0] outPos;
  logic [RC_W-1:0]   rspCnt;
  logic [RC_W:0]     wrPos;
  logic [RC_W:0]     rspTotal;
  logic              oversize;
  logic [7:0]        capFrame [CAP_LEN];

  // inbound buffer: saturating count, one register per slot
  always_ff @(posedge clk) begin
    if (!rstN)                        inLen <= '0;
    else if (inClear || ctl.dropReq)  inLen <= '0;
    else if (inPush && inLen != '1)   inLen <= inLen + 1'b1;
  end

  for (genvar g = 0; g < IN_DEPTH; g++) begin : g_inSlot
    always_ff @(posedge clk) begin
      if (inPush && !inClear && inLen == IN_LW'(g)) inBuf[g] <= inByte;
    end
  end

  always_comb begin
    stat.shortReq = inLen < IN_LW'(4);
    stat.badLen   = (inLen > IN_LW'(IN_DEPTH)) ||
                    (16'(inBuf[0]) != 16'(inLen) - 16'd1);
    stat.isCap    = (inBuf[1] == NETFN_APP_REQ) && (inBuf[3] == CMD_CAP_QUERY);
    stat.lastFwd  = (IN_LW'(fwdIdx) == inLen - IN_LW'(1));
  end

  // forward walk: byte 1, then bytes 3.. (sequence byte skipped)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdIdx   <= '0;
      seqSaved <= '0;
    end else if (ctl.startFwd) begin
      fwdIdx   <= IN_IW'(1);
      seqSaved <= inBuf[2];
    end else if (ctl.sendByte) begin
      fwdIdx <= (fwdIdx == IN_IW'(1)) ? IN_IW'(3) : fwdIdx + 1'b1;
    end
  end

  assign fwdByte = inBuf[fwdIdx];

  // locally built capabilities answer
  always_comb begin
    capFrame[0] = 8'd9;
    capFrame[1] = inBuf[1] | 8'h04;
    capFrame[2] = inBuf[2];
    capFrame[3] = inBuf[3];
    capFrame[4] = 8'h00;
    capFrame[5] = 8'h01;
    capFrame[6] = CAP_IN;
    capFrame[7] = CAP_OUT;
    capFrame[8] = 8'd10;
    capFrame[9] = 8'h00;
  end

  // response placement: byte 0 -> slot 1, byte k>0 -> slot k+2
  assign wrPos    = (rspCnt == '0) ? (RC_W+1)'(1) : {1'b0, rspCnt} + (RC_W+1)'(2);
  assign rspTotal = {1'b0, rspCnt} + (RC_W+1)'(1);
  assign oversize = rspTotal > (RC_W+1)'(OUT_DEPTH - 2);

  always_ff @(posedge clk) begin
    if (!rstN)                               rspCnt <= '0;
    else if (ctl.finRsp)                     rspCnt <= '0;
    else if (ctl.takeRsp && rspCnt != '1)    rspCnt <= rspCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.ansLocal) begin
      for (int k = 0; k < CAP_LEN; k++) outBuf[k] <= capFrame[k];
    end
    if (ctl.takeRsp && wrPos < (RC_W+1)'(OUT_DEPTH)) begin
      outBuf[OUT_IW'(wrPos)] <= rspData;
    end
    if (ctl.finRsp) begin
      outBuf[0] <= oversize ? 8'd4 : 8'(rspTotal + (RC_W+1)'(1));
      outBuf[2] <= seqSaved;
      if (oversize) outBuf[4] <= CC_TOO_LONG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLen <= '0;
      outPos <= '0;
    end else if (ctl.ansLocal) begin
      outLen <= OUT_LW'(CAP_LEN);
      outPos <= '0;
    end else if (ctl.finRsp) begin
      outLen <= oversize ? OUT_LW'(5) : OUT_LW'(rspTotal + (RC_W+1)'(2));
      outPos <= '0;
    end else if (ctl.takeRsp && rspCnt == '0) begin
      outLen <= '0;
      outPos <= '0;
    end else if (outPop && outAvail) begin
      if (outPos + 1'b1 == outLen) begin
        outLen <= '0;
        outPos <= '0;
      end else begin
        outPos <= outPos + 1'b1;
      end
    end
  end

  assign outAvail = outPos < outLen;
  assign outByte  = outAvail ? outBuf[OUT_IW'(outPos)] : 8'hFF;

endmodule

// File: rtl/bt_msg_framer.sv
module bt_msg_framer
  import bt_framer_pkg::*;
#(
  parameter int IN_DEPTH  = 64,
  parameter int OUT_DEPTH = 64,
  parameter int ID_W      = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inPush,
  input  logic [7:0]      inByte,
  input  logic            inClear,
  input  logic            reqGo,
  output logic            busy,
  output logic            doneEvt,
  output logic            beValid,
  output logic [7:0]      beData,
  output logic            beLast,
  output logic [ID_W-1:0] beId,
  input  logic            beReady,
  input  logic            rspValid,
  input  logic [7:0]      rspData,
  input  logic            rspLast,
  input  logic [ID_W-1:0] rspId,
  input  logic            outPop,
  output logic [7:0]      outByte,
  output logic            outAvail
);

  frCtl_t  ctl;
  frStat_t stat;

  bt_framer_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqGo(reqGo), .stat(stat), .beReady(beReady),
    .rspValid(rspValid), .rspLast(rspLast), .rspId(rspId), .ctl(ctl),
    .busy(busy), .doneEvt(doneEvt), .beValid(beValid), .beLast(beLast),
    .beId(beId)
  );

  bt_framer_dp #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inPush(inPush), .inByte(inByte),
    .inClear(inClear), .ctl(ctl), .stat(stat), .fwdByte(beData),
    .rspData(rspData), .outPop(outPop), .outByte(outByte),
    .outAvail(outAvail)
  );

endmodule

// File: rtl/bt_msg_framer_chk.sv
module bt_msg_framer_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqGo,
  input logic            busy,
  input logic            doneEvt,
  input logic            beValid,
  input logic [7:0]      beData,
  input logic            beLast,
  input logic [ID_W-1:0] beId,
  input logic            beReady,
  input logic [7:0]      outByte,
  input logic            outAvail
);

  AST_STROBE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqGo && !busy) |=> (busy || doneEvt)); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> !busy); // R9

  AST_DONE_HAS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> outAvail); // R11

  AST_EMPTY_READS_FF: assert property (@(posedge clk) disable iff (!rstN)
    !outAvail |-> (outByte == 8'hFF)); // R11

  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (beValid && !beReady) |=> (beValid && $stable(beData) && $stable(beLast) && $stable(beId))); // R5

  AST_SEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    beValid |-> (busy && !doneEvt)); // R10

endmodule

bind bt_msg_framer bt_msg_framer_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqGo(reqGo), .busy(busy), .doneEvt(doneEvt),
  .beValid(beValid), .beData(beData), .beLast(beLast), .beId(beId),
  .beReady(beReady), .outByte(outByte), .outAvail(outAvail)
);

// File: tb/bt_msg_framer_bench.sv
module bt_msg_framer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inPush = 1'b0, inClear = 1'b0, reqGo = 1'b0;
  logic [7:0] inByte = '0;
  logic       busy, doneEvt, beValid, beLast, beReady = 1'b0;
  logic [7:0] beData;
  logic [7:0] beId;
  logic       rspValid = 1'b0, rspLast = 1'b0;
  logic [7:0] rspData = '0, rspId = '0;
  logic       outPop = 1'b0;
  logic [7:0] outByte;
  logic       outAvail;

  int checks = 0;
  int failures = 0;
  logic [7:0] expBuf [0:127];
  logic [7:0] rspBuf [0:127];
  logic [7:0] gotBe  [0:127];
  int         gotBeN;
  logic       gotBeLast;
  logic [7:0] gotBeId;

  always #10 clk = ~clk;

  bt_msg_framer u_bt_msg_framer (
    .clk(clk), .rstN(rstN), .inPush(inPush), .inByte(inByte),
    .inClear(inClear), .reqGo(reqGo), .busy(busy), .doneEvt(doneEvt),
    .beValid(beValid), .beData(beData), .beLast(beLast), .beId(beId),
    .beReady(beReady), .rspValid(rspValid), .rspData(rspData),
    .rspLast(rspLast), .rspId(rspId), .outPop(outPop), .outByte(outByte),
    .outAvail(outAvail)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    inPush = 1'b1; inByte = b;
    @(negedge clk);
    inPush = 1'b0;
  endtask

  task automatic clearIn();
    inClear = 1'b1;
    @(negedge clk);
    inClear = 1'b0;
  endtask

  task automatic strobe();
    reqGo = 1'b1;
    @(negedge clk);
    reqGo = 1'b0;
  endtask

  task automatic pushCap(input logic [7:0] seq);
    push(8'd3); push(8'h18); push(seq); push(8'h36);
  endtask

  task automatic readFrame(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      check(req, outAvail, 1);
      check(req, outByte, expBuf[i]);
      outPop = 1'b1;
      @(negedge clk);
      outPop = 1'b0;
    end
    check("R11 empty after frame", outAvail, 0);
    check("R11 empty reads FF", outByte, 8'hFF);
  endtask

  task automatic setCapExp(input logic [7:0] seq);
    expBuf[0] = 8'd9;  expBuf[1] = 8'h1C; expBuf[2] = seq;  expBuf[3] = 8'h36;
    expBuf[4] = 8'h00; expBuf[5] = 8'h01; expBuf[6] = 8'd64; expBuf[7] = 8'd64;
    expBuf[8] = 8'd10; expBuf[9] = 8'h00;
  endtask

  // backend sink with a stalling ready pattern, also checks hold (R5)
  task automatic collectBe();
    logic       stalled = 1'b0;
    logic [7:0] heldData = '0;
    gotBeN = 0; gotBeLast = 1'b0;
    for (int k = 0; k < 100 && !gotBeLast; k++) begin
      if (stalled) begin
        check("R5 valid held while stalled", beValid, 1);
        check("R5 data held while stalled", beData, heldData);
      end
      beReady = (k % 3 != 0);
      stalled = beValid && !beReady;
      heldData = beData;
      if (beValid && beReady) begin
        gotBe[gotBeN] = beData;
        gotBeN++;
        gotBeLast = beLast;
        gotBeId = beId;
      end
      @(negedge clk);
    end
    beReady = 1'b0;
  endtask

  task automatic sendRsp(input logic [7:0] id, input int n, output logic sawDone);
    for (int i = 0; i < n; i++) begin
      rspValid = 1'b1; rspData = rspBuf[i]; rspLast = (i == n - 1); rspId = id;
      @(negedge clk);
    end
    rspValid = 1'b0; rspLast = 1'b0;
    sawDone = doneEvt;
  endtask

  task automatic testReset();
    check("R1 busy", busy, 0);
    check("R1 doneEvt", doneEvt, 0);
    check("R1 beValid", beValid, 0);
    check("R1 outAvail", outAvail, 0);
    check("R1 outByte", outByte, 8'hFF);
  endtask

  task automatic testLocal();
    clearIn();
    pushCap(8'h22);
    strobe();
    check("R9 done after local answer", doneEvt, 1);
    check("R9 busy cleared", busy, 0);
    check("R4 no backend traffic", beValid, 0);
    setCapExp(8'h22);
    readFrame("R4 capability frame", 10);
  endtask

  task automatic testShort();
    clearIn();
    push(8'd3); push(8'h18); push(8'h33);
    strobe();
    check("R2 busy set", busy, 1);
    check("R2 no done", doneEvt, 0);
    @(negedge clk);
    check("R2 no frame", outAvail, 0);
    check("R2 no backend", beValid, 0);
    push(8'h36);
    strobe();
    check("R2 kept bytes complete request", doneEvt, 1);
    setCapExp(8'h33);
    readFrame("R2 completed frame", 10);
  endtask

  task automatic testMismatch();
    clearIn();
    push(8'd5); push(8'h18); push(8'h01); push(8'h36);
    strobe();
    check("R3 busy stays", busy, 1);
    check("R3 no done", doneEvt, 0);
    check("R3 no frame", outAvail, 0);
    pushCap(8'h44);
    strobe();
    check("R3 inbound was cleared", doneEvt, 1);
    setCapExp(8'h44);
    readFrame("R3 frame after drop", 10);
  endtask

  task automatic testOverrun();
    clearIn();
    push(8'd64); push(8'h18); push(8'h11); push(8'h36);
    for (int i = 4; i < 65; i++) push(8'h00);
    strobe();
    check("R12 overrun dropped", doneEvt, 0);
    check("R12 busy stays", busy, 1);
    check("R12 no frame", outAvail, 0);
    pushCap(8'h55);
    strobe();
    check("R12 inbound cleared", doneEvt, 1);
    setCapExp(8'h55);
    readFrame("R12 frame after overrun", 10);
  endtask

  task automatic testForward();
    logic sawDone;
    clearIn();
    push(8'd5); push(8'h1C); push(8'h42); push(8'h01); push(8'hAA); push(8'hBB);
    strobe();
    check("R5 busy while forwarding", busy, 1);
    collectBe();
    check("R5 byte count", gotBeN, 4);
    check("R5 netfn", gotBe[0], 8'h1C);
    check("R5 cmd", gotBe[1], 8'h01);
    check("R5 data0", gotBe[2], 8'hAA);
    check("R5 data1", gotBe[3], 8'hBB);
    check("R5 last flagged", gotBeLast, 1);
    check("R6 first id", gotBeId, 0);
    strobe();
    @(negedge clk);
    check("R10 strobe ignored no send", beValid, 0);
    check("R10 strobe ignored no done", doneEvt, 0);
    check("R10 busy held", busy, 1);
    rspBuf[0] = 8'h20; rspBuf[1] = 8'h01; rspBuf[2] = 8'h00; rspBuf[3] = 8'h55;
    sendRsp(8'd5, 4, sawDone);
    check("R6 wrong id no done", sawDone, 0);
    check("R6 wrong id no frame", outAvail, 0);
    check("R6 wrong id busy", busy, 1);
    sendRsp(8'd0, 4, sawDone);
    check("R9 done on response", sawDone, 1);
    check("R9 busy cleared", busy, 0);
    expBuf[0] = 8'd5; expBuf[1] = 8'h20; expBuf[2] = 8'h42;
    expBuf[3] = 8'h01; expBuf[4] = 8'h00; expBuf[5] = 8'h55;
    readFrame("R7 response frame", 6);
  endtask

  task automatic testOversize();
    logic sawDone;
    clearIn();
    push(8'd3); push(8'h30); push(8'h07); push(8'h09);
    strobe();
    collectBe();
    check("R5 short request count", gotBeN, 2);
    check("R5 short request cmd", gotBe[1], 8'h09);
    check("R6 id incremented", gotBeId, 1);
    rspBuf[0] = 8'h34; rspBuf[1] = 8'h09;
    for (int i = 2; i < 63; i++) rspBuf[i] = 8'(i);
    sendRsp(8'd1, 63, sawDone);
    check("R8 done on oversize", sawDone, 1);
    expBuf[0] = 8'd4; expBuf[1] = 8'h34; expBuf[2] = 8'h07;
    expBuf[3] = 8'h09; expBuf[4] = 8'hCA;
    readFrame("R8 error frame", 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocal();
    testShort();
    testMismatch();
    testOverrun();
    testForward();
    testOversize();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule